// File: doc/BRIEF.md
# Multi-Slot Interval Timer Unit

This block holds sixteen independent countdown slots that share one servicing task. Software programs a slot with a single 16-bit command word that packs the slot's new state, an 8-bit count and the slot index. The command either replaces the slot's count (load) or adds to it (add-to). The add-to form lets a periodic timer restart from where it stopped, so the period does not drift by the service latency. Counting advances on an external tick-enable pulse. When a slot runs out it stops and marks a pending wakeup.

A wakeup line stays high while any slot is pending. The servicing task reads one byte that names the highest-numbered pending slot together with that slot's state. Reading clears that one pending wakeup. Slot 15 is kept for the refresh and real-time-clock service, so it always wins arbitration.

Commands must be spaced at least seven cycles apart. A small two-state gate enforces the spacing. GATE_OPEN accepts a command and moves to GATE_COOL through the ACCEPT transition. GATE_COOL counts the cycles of the cooling window and returns to GATE_OPEN through the EXPIRE transition once the window ends. A command that arrives while the gate is in GATE_COOL is dropped and sets a sticky violation flag.

Top module: `interval_timer_bank`

## Requirements
- R1: Command word fields: cmd_word[15:12] is the new state, cmd_word[11:4] is the count data and cmd_word[3:0] is the slot index. cmd_add=0 selects load and cmd_add=1 selects add-to.
- R2: A load with a nonzero state sets the slot's count to the data field and arms the slot. An armed slot with count n sets its pending bit on the n-th tick pulse after the command; a count of 0 behaves like 1.
- R3: An add-to sets the slot's count to its current count plus the data field, modulo 256. It replaces the state and re-arms the slot when the new state is nonzero.
- R4: A command is accepted only when at least 7 cycles have passed since the last accepted command. A command that comes sooner has no effect on any slot and sets the violation output, which stays high until reset.
- R5: A command whose state field is 0 disables the slot, and a disabled slot never raises a wakeup.
- R6: After a slot fires it stays stopped. It raises no further wakeup until a new command is issued for it.
- R7: rd_data[3:0] is the index of the highest-priority pending slot and rd_data[7:4] is that slot's state. rd_data is 0 when nothing is pending. A cycle with rd_en high clears the pending bit of the slot shown.
- R8: Among pending slots, the highest slot number is reported first, so slot 15 has top priority.
- R9: wakeup is high exactly while at least one pending bit is set.
- R10: After reset all slots are disabled, no wakeup is pending, violation is low and the gate accepts a command at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse for all slots |
| cmd_valid | input | 1 | Command strobe |
| cmd_add | input | 1 | 0 = load, 1 = add-to |
| cmd_word | input | 16 | Packed state, data and slot index |
| rd_en | input | 1 | Read strobe; clears the pending bit of the reported slot |
| rd_data | output | 8 | {state, slot index} of the reported pending slot |
| wakeup | output | 1 | High while any slot is pending |
| violation | output | 1 | Sticky flag for a command that broke the spacing rule |

## Verification
The bench builds the block with its default parameters: sixteen slots, 4-bit states, 8-bit counts and a 7-cycle spacing window. With that configuration every slot can be swept in turn. Each slot's firing tick, reported state, read clearing and one-shot stop are checked against counts worked out arithmetically in the bench. The spacing rule is probed on both sides of its boundary, at 6 and at 7 cycles. Priority ordering, add-to extension, zero-count loads and disabled slots are each exercised directly.

// File: rtl/itb_pkg.sv
package itb_pkg;
    typedef enum logic [0:0] {
        GATE_OPEN = 1'b0,
        GATE_COOL = 1'b1
    } gate_state_t;
endpackage

// File: rtl/itb_cmd_gate.sv
module itb_cmd_gate
    import itb_pkg::*;
#(
    parameter int MIN_GAP = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    output logic accept,
    output logic violation
);
    localparam int GW = $clog2(MIN_GAP + 1);

    gate_state_t state_q, state_d;
    logic [GW-1:0] gap_q, gap_d;
    logic viol_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            GATE_OPEN: begin
                if (cmd_valid) begin
                    state_d = GATE_COOL;          // ACCEPT
                    gap_d   = GW'(MIN_GAP - 1);
                end
            end
            GATE_COOL: begin
                if (gap_q == GW'(1)) begin
                    state_d = GATE_OPEN;          // EXPIRE
                    gap_d   = '0;
                end else begin
                    gap_d = gap_q - GW'(1);
                end
            end
            default: state_d = GATE_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_OPEN;
            gap_q   <= '0;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
            if (cmd_valid && state_q == GATE_COOL) viol_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        accept    = cmd_valid && (state_q == GATE_OPEN);
        violation = viol_q;
    end

    a_r4_no_close_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    a_r4_violation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
    a_r4_early_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !accept) |=> violation);
endmodule

// File: rtl/itb_slot.sv
module itb_slot #(
    parameter int STATE_W = 4,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr,
    input  logic               wr_add,
    input  logic [STATE_W-1:0] wr_state,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               clr,
    output logic               pend,
    output logic [STATE_W-1:0] state_o
);
    logic [STATE_W-1:0] st_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               armed_q;
    logic               pend_q;
    logic               fire;

    assign fire = !wr && tick && armed_q && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (wr) begin
                st_q    <= wr_state;
                armed_q <= (wr_state != '0);
                cnt_q   <= wr_add ? cnt_q + wr_data : wr_data;
            end else if (tick && armed_q) begin
                if (cnt_q <= CNT_W'(1)) begin
                    cnt_q   <= '0;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
            if (fire)     pend_q <= 1'b1;
            else if (clr) pend_q <= 1'b0;
        end
    end

    assign pend    = pend_q;
    assign state_o = st_q;

    // R6: once fired, a slot cannot set pending again without a command
    a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr) |=> !armed_q);
    // R5: a disarmed slot never raises a new pending bit on the next edge
    a_r5_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !pend_q) |=> !pend_q);
endmodule

// File: rtl/itb_arbiter.sv
module itb_arbiter #(
    parameter int NSLOTS = 16
) (
    input  logic [NSLOTS-1:0]         pend,
    output logic                      any,
    output logic [$clog2(NSLOTS)-1:0] idx,
    output logic [NSLOTS-1:0]         gnt
);
    localparam int IW = $clog2(NSLOTS);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NSLOTS; i++) gnt[i] = any && (idx == IW'(i));
    end

    // R8: at most one slot granted, and the top pending slot wins
    always_comb begin
        a_r8_single_grant: assert ($onehot0(gnt));
        if (pend[NSLOTS-1]) a_r8_top_slot: assert (idx == IW'(NSLOTS - 1));
    end
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank #(
    parameter int NSLOTS  = 16,
    parameter int STATE_W = 4,
    parameter int CNT_W   = 8,
    parameter int MIN_GAP = 7,
    parameter int IDX_W   = $clog2(NSLOTS),
    parameter int CMD_W   = STATE_W + CNT_W + IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     cmd_valid,
    input  logic                     cmd_add,
    input  logic [CMD_W-1:0]         cmd_word,
    input  logic                     rd_en,
    output logic [STATE_W+IDX_W-1:0] rd_data,
    output logic                     wakeup,
    output logic                     violation
);
    logic [STATE_W-1:0] f_state;
    logic [CNT_W-1:0]   f_data;
    logic [IDX_W-1:0]   f_slot;
    logic               accept;
    logic [NSLOTS-1:0]  pend, gnt;
    logic               any;
    logic [IDX_W-1:0]   idx;
    logic [STATE_W-1:0] slot_state [NSLOTS];

    assign f_state = cmd_word[CMD_W-1 -: STATE_W];
    assign f_data  = cmd_word[IDX_W +: CNT_W];
    assign f_slot  = cmd_word[IDX_W-1:0];

    itb_cmd_gate #(.MIN_GAP(MIN_GAP)) u_gate (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .accept(accept), .violation(violation)
    );

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        itb_slot #(.STATE_W(STATE_W), .CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .wr(accept && (f_slot == IDX_W'(s))),
            .wr_add(cmd_add), .wr_state(f_state), .wr_data(f_data),
            .clr(rd_en && gnt[s]),
            .pend(pend[s]), .state_o(slot_state[s])
        );
    end

    itb_arbiter #(.NSLOTS(NSLOTS)) u_arb (
        .pend(pend), .any(any), .idx(idx), .gnt(gnt)
    );

    assign wakeup  = any;
    assign rd_data = any ? {slot_state[idx], idx} : '0;

    // R9: wakeup drops after a read only when nothing else was pending and nothing fired
    a_r9_wakeup_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wakeup && !rd_en) |=> wakeup);
    // R7: a read of a lone pending slot without tick empties the bank
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $countones(pend) == 1 && !tick) |=> !wakeup);
endmodule

// File: tb/tb_interval_timer_bank.sv
module tb_interval_timer_bank;
    logic clk = 1'b0;
    logic rst_n, tick, cmd_valid, cmd_add, rd_en;
    logic [15:0] cmd_word;
    logic [7:0]  rd_data;
    logic        wakeup, violation;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    interval_timer_bank dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_add(cmd_add), .cmd_word(cmd_word), .rd_en(rd_en),
        .rd_data(rd_data), .wakeup(wakeup), .violation(violation)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; cmd_valid = 1'b0; cmd_add = 1'b0;
        rd_en = 1'b0; cmd_word = '0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic cmd(input bit add, input int st, input int data, input int slot);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_add = add;
        cmd_word  = {st[3:0], data[7:0], slot[3:0]};
        @(negedge clk);
        cmd_valid = 1'b0; cmd_add = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        chk(wakeup == 1'b0, "R10 wakeup", wakeup, 0);
        chk(rd_data == 8'd0, "R10 rd_data", rd_data, 0);
        chk(violation == 1'b0, "R10 violation", violation, 0);

        // R1 R2 R6 R7 R9: sweep every slot
        for (int s = 0; s < 16; s++) begin
            int d  = s + 1;
            int st = (s % 15) + 1;
            idle(7);
            cmd(1'b0, st, d, s);
            ticks(d - 1);
            chk(wakeup == 1'b0, "R2 early", wakeup, 0);
            ticks(1);
            chk(wakeup == 1'b1, "R9 fired", wakeup, 1);
            chk(rd_data == {st[3:0], s[3:0]}, "R7 rd_data", rd_data, {st[3:0], s[3:0]});
            rd();
            chk(wakeup == 1'b0, "R7 cleared", wakeup, 0);
            ticks(2);
            chk(wakeup == 1'b0, "R6 one-shot", wakeup, 0);
        end

        // R2: zero count fires on first tick
        idle(7);
        cmd(1'b0, 1, 0, 9);
        ticks(1);
        chk(rd_data == 8'h19, "R2 zero count", rd_data, 8'h19);
        rd();

        // R3: add-to extends count
        do_reset();
        cmd(1'b0, 6, 10, 3);
        ticks(4);
        idle(7);
        cmd(1'b1, 6, 5, 3);
        ticks(10);
        chk(wakeup == 1'b0, "R3 extended", wakeup, 0);
        ticks(1);
        chk(rd_data == 8'h63, "R3 add fire", rd_data, 8'h63);
        rd();
        // R6 then R3: add re-arms a fired slot
        idle(7);
        cmd(1'b1, 2, 3, 3);
        ticks(3);
        chk(rd_data == 8'h23, "R3 rearm", rd_data, 8'h23);
        rd();

        // R5: state zero disables
        idle(7);
        cmd(1'b0, 0, 2, 4);
        ticks(5);
        chk(wakeup == 1'b0, "R5 disabled", wakeup, 0);

        // R4: gap 6 rejected
        do_reset();
        cmd(1'b0, 1, 50, 1);
        idle(4);
        cmd(1'b0, 1, 1, 2);
        chk(violation == 1'b1, "R4 gap6 flag", violation, 1);
        ticks(1);
        chk(wakeup == 1'b0, "R4 gap6 ignored", wakeup, 0);
        idle(7);
        cmd(1'b0, 3, 1, 5);
        ticks(1);
        chk(violation == 1'b1, "R4 sticky", violation, 1);
        chk(rd_data == 8'h35, "R4 later accepted", rd_data, 8'h35);
        rd();

        // R4: gap 7 accepted
        do_reset();
        cmd(1'b0, 1, 50, 1);
        idle(5);
        cmd(1'b0, 4, 1, 2);
        chk(violation == 1'b0, "R4 gap7 flag", violation, 0);
        ticks(1);
        chk(rd_data == 8'h42, "R4 gap7 applied", rd_data, 8'h42);
        rd();

        // R8: priority order among pending slots
        do_reset();
        cmd(1'b0, 2, 3, 0);
        idle(5);
        cmd(1'b0, 5, 3, 7);
        idle(5);
        cmd(1'b0, 9, 3, 15);
        ticks(3);
        chk(rd_data == 8'h9F, "R8 first", rd_data, 8'h9F);
        rd();
        chk(rd_data == 8'h57, "R8 second", rd_data, 8'h57);
        rd();
        chk(rd_data == 8'h20, "R8 third", rd_data, 8'h20);
        rd();
        chk(wakeup == 1'b0, "R9 empty", wakeup, 0);
        chk(rd_data == 8'h00, "R7 empty", rd_data, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule